// File: doc/BRIEF.md
# Configurable Input Capture Macrocell Group

This block sits between input pins and a product-term array. It holds two banks of capture cells. One bank serves the dedicated input pins. The other serves the bidirectional pins. Every cell in a bank behaves the same way, according to a 2-bit mode setting owned by that bank:

- **Pass-through:** the cell forwards its pin directly.
- **Latched:** the cell holds the pin in a transparent latch.
- **Registered:** the cell samples the pin on a rising edge.

Both banks share one control pin. In latched mode it is the latch enable, and in registered mode it is the capture clock.

Each cell always runs both a latch and a flip-flop, whatever the mode. The bank mode only picks which of the three values reaches the array. The mode is a static configuration input, so switching the mode does not disturb the stored state. Every cell output reaches the array twice, in its true form and in its inverted form.

The capture registers have a configuration reset. The reset is synchronous to the shared control pin: if it is high at a rising control edge, every capture register takes zero. The latches do not see this reset.

Top module: `incap_group`

## Requirements
- R1: With bank mode 2'b00 (pass-through), each true output of that bank equals its pin, whatever the state of the control pin.
- R2: Bank mode 2'b11 is reserved and behaves exactly like mode 2'b00.
- R3: With bank mode 2'b01 (latched) and the control pin high, each true output follows its pin.
- R4: With bank mode 2'b01 and the control pin low, each true output holds the pin value it had when the control pin fell. Pin changes while the control pin is low have no effect.
- R5: With bank mode 2'b10 (registered), each true output takes its pin value at a rising edge of the control pin and holds it otherwise. Pin changes and falling edges have no effect.
- R6: When the configuration reset is high at a rising control edge, every capture register becomes 0. A bank in mode 2'b10 then shows 0 on every true output.
- R7: Every complement output is the bitwise inverse of the matching true output, in every mode.
- R8: The two banks are configured independently. The mode of one bank never changes the outputs of the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_ctl | input | 1 | Shared control pin: latch enable in latched mode, capture clock in registered mode |
| cfg_rst | input | 1 | Configuration reset, sampled at the rising edge of cap_ctl; clears the capture registers |
| ded_mode | input | 2 | Mode of the dedicated-input bank (00 pass, 01 latch, 10 register, 11 pass) |
| bio_mode | input | 2 | Mode of the bidirectional-pin bank, same encoding |
| ded_pin | input | N_DED | Dedicated input pins |
| bio_pin | input | N_BIO | Bidirectional pins, in their input role |
| ded_true | output | N_DED | True outputs of the dedicated bank toward the array |
| ded_comp | output | N_DED | Inverted outputs of the dedicated bank |
| bio_true | output | N_BIO | True outputs of the bidirectional bank |
| bio_comp | output | N_BIO | Inverted outputs of the bidirectional bank |

## Verification
- **Timing of results:** pass-through results and latch-transparent results are combinational, so they are due within the same time step as the pin change. A registered result is due at the rising control edge and then stays fixed until the next rising edge.
- **Sampling:** the bench owns the control pin. It never changes a pin and the control pin in the same step, and it samples one time unit after each single change. Each sample therefore reflects exactly one event.
- **Expected values:** a bench model tracks the latch and register contents per bank. The sweep covers every pair of bank modes and every 4-bit pin value.

// File: rtl/incap_pkg.sv
package incap_pkg;

   typedef enum logic [1:0] {
      SEL_PASS  = 2'b00,
      SEL_LATCH = 2'b01,
      SEL_REG   = 2'b10
   } cell_sel_e;

   localparam int unsigned MODE_W  = 2;
   localparam int unsigned MAX_PIN = 64;

   // The reserved code falls back to pass-through.
   function automatic cell_sel_e decode_mode(input logic [MODE_W-1:0] code);
      case (code)
         2'b01:   decode_mode = SEL_LATCH;
         2'b10:   decode_mode = SEL_REG;
         default: decode_mode = SEL_PASS;
      endcase
   endfunction

endpackage

// File: rtl/incap_cell.sv
module incap_cell
   import incap_pkg::*;
(
   input  logic      cap_ctl,
   input  logic      cfg_rst,
   input  cell_sel_e sel,
   input  logic      pin,
   output logic      q_true,
   output logic      q_comp
);

   logic lat_q;
   logic reg_q;

   // Transparent latch, open while the control pin is high.
   always_latch begin
      if (cap_ctl) begin
         lat_q <= pin;
      end
   end

   // Edge capture with synchronous configuration reset.
   always_ff @(posedge cap_ctl) begin
      if (cfg_rst) begin
         reg_q <= 1'b0;
      end else begin
         reg_q <= pin;
      end
   end

   always_comb begin
      case (sel)
         SEL_LATCH: q_true = lat_q;
         SEL_REG:   q_true = reg_q;
         default:   q_true = pin;
      endcase
   end

   assign q_comp = ~q_true;

endmodule

// File: rtl/incap_bank.sv
module incap_bank
   import incap_pkg::*;
#(
   parameter int unsigned WIDTH = 10
) (
   input  logic              cap_ctl,
   input  logic              cfg_rst,
   input  logic [MODE_W-1:0] mode,
   input  logic [WIDTH-1:0]  pin,
   output logic [WIDTH-1:0]  q_true,
   output logic [WIDTH-1:0]  q_comp
);

   cell_sel_e bank_sel;

   // One decode per bank, shared by all its cells.
   assign bank_sel = decode_mode(mode);

   generate
      if (WIDTH < 1 || WIDTH > MAX_PIN) begin : g_bad_width
         $error("incap_bank: WIDTH out of range");
      end
   endgenerate

   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_cell
         incap_cell u_cell (
            .cap_ctl (cap_ctl),
            .cfg_rst (cfg_rst),
            .sel     (bank_sel),
            .pin     (pin[i]),
            .q_true  (q_true[i]),
            .q_comp  (q_comp[i])
         );
      end
   endgenerate

endmodule

// File: rtl/incap_group.sv
module incap_group
   import incap_pkg::*;
#(
   parameter int unsigned N_DED = 10,
   parameter int unsigned N_BIO = 10
) (
   input  logic              cap_ctl,
   input  logic              cfg_rst,
   input  logic [MODE_W-1:0] ded_mode,
   input  logic [MODE_W-1:0] bio_mode,
   input  logic [N_DED-1:0]  ded_pin,
   input  logic [N_BIO-1:0]  bio_pin,
   output logic [N_DED-1:0]  ded_true,
   output logic [N_DED-1:0]  ded_comp,
   output logic [N_BIO-1:0]  bio_true,
   output logic [N_BIO-1:0]  bio_comp
);

   localparam int unsigned N_TOTAL = N_DED + N_BIO;

   generate
      if (N_TOTAL > 2 * MAX_PIN) begin : g_bad_total
         $error("incap_group: too many cells");
      end
   endgenerate

   incap_bank #(.WIDTH(N_DED)) u_ded (
      .cap_ctl (cap_ctl),
      .cfg_rst (cfg_rst),
      .mode    (ded_mode),
      .pin     (ded_pin),
      .q_true  (ded_true),
      .q_comp  (ded_comp)
   );

   incap_bank #(.WIDTH(N_BIO)) u_bio (
      .cap_ctl (cap_ctl),
      .cfg_rst (cfg_rst),
      .mode    (bio_mode),
      .pin     (bio_pin),
      .q_true  (bio_true),
      .q_comp  (bio_comp)
   );

endmodule

// File: rtl/incap_group_chk.sv
module incap_group_chk #(
   parameter int unsigned N_DED = 10,
   parameter int unsigned N_BIO = 10
) (
   input logic             cap_ctl,
   input logic             cfg_rst,
   input logic [1:0]       ded_mode,
   input logic [1:0]       bio_mode,
   input logic [N_DED-1:0] ded_pin,
   input logic [N_BIO-1:0] bio_pin,
   input logic [N_DED-1:0] ded_true,
   input logic [N_DED-1:0] ded_comp,
   input logic [N_BIO-1:0] bio_true,
   input logic [N_BIO-1:0] bio_comp
);

   // R1
   ded_pass_chk: assert property (@(posedge cap_ctl) disable iff (cfg_rst)
      (ded_mode == 2'b00) |-> (ded_true == ded_pin));

   // R2
   ded_rsvd_chk: assert property (@(posedge cap_ctl) disable iff (cfg_rst)
      (ded_mode == 2'b11) |-> (ded_true == ded_pin));

   // R5
   ded_capture_chk: assert property (@(posedge cap_ctl) disable iff (cfg_rst)
      ((ded_mode == 2'b10) && ($past(ded_mode) == 2'b10) && !$past(cfg_rst))
      |-> (ded_true == $past(ded_pin)));

   // R6
   ded_clear_chk: assert property (@(posedge cap_ctl) disable iff (cfg_rst)
      ((ded_mode == 2'b10) && $past(cfg_rst)) |-> (ded_true == '0));

   // R7
   ded_inverse_chk: assert property (@(posedge cap_ctl) disable iff (cfg_rst)
      ded_comp == ~ded_true);

   // R8
   bio_capture_chk: assert property (@(posedge cap_ctl) disable iff (cfg_rst)
      ((bio_mode == 2'b10) && ($past(bio_mode) == 2'b10) && !$past(cfg_rst))
      |-> (bio_true == $past(bio_pin)));

   // R8
   bio_pass_chk: assert property (@(posedge cap_ctl) disable iff (cfg_rst)
      ((bio_mode == 2'b00) || (bio_mode == 2'b11)) |-> (bio_true == bio_pin));

   // R7
   bio_inverse_chk: assert property (@(posedge cap_ctl) disable iff (cfg_rst)
      bio_comp == ~bio_true);

endmodule

bind incap_group incap_group_chk #(.N_DED(N_DED), .N_BIO(N_BIO)) u_chk (
   .cap_ctl  (cap_ctl),
   .cfg_rst  (cfg_rst),
   .ded_mode (ded_mode),
   .bio_mode (bio_mode),
   .ded_pin  (ded_pin),
   .bio_pin  (bio_pin),
   .ded_true (ded_true),
   .ded_comp (ded_comp),
   .bio_true (bio_true),
   .bio_comp (bio_comp)
);

// File: tb/tb_incap_group.sv
module tb_incap_group;

   localparam int W      = 4;
   localparam int PERIOD = 10;

   logic         cap_ctl;
   logic         cfg_rst;
   logic [1:0]   ded_mode;
   logic [1:0]   bio_mode;
   logic [W-1:0] ded_pin;
   logic [W-1:0] bio_pin;
   logic [W-1:0] ded_true;
   logic [W-1:0] ded_comp;
   logic [W-1:0] bio_true;
   logic [W-1:0] bio_comp;

   int errors = 0;
   int checks = 0;

   // Bench model state, per bank.
   logic [W-1:0] d_lat, d_reg, b_lat, b_reg;

   incap_group #(.N_DED(W), .N_BIO(W)) dut (
      .cap_ctl  (cap_ctl),
      .cfg_rst  (cfg_rst),
      .ded_mode (ded_mode),
      .bio_mode (bio_mode),
      .ded_pin  (ded_pin),
      .bio_pin  (bio_pin),
      .ded_true (ded_true),
      .ded_comp (ded_comp),
      .bio_true (bio_true),
      .bio_comp (bio_comp)
   );

   function automatic string tag_of(logic [1:0] m, logic en);
      case (m)
         2'b00:   tag_of = "R1";
         2'b11:   tag_of = "R2";
         2'b01:   tag_of = en ? "R3" : "R4";
         default: tag_of = "R5";
      endcase
   endfunction

   function automatic logic [W-1:0] expect_of(logic [1:0] m, logic [W-1:0] p,
                                              logic [W-1:0] l, logic [W-1:0] r);
      case (m)
         2'b01:   expect_of = l;
         2'b10:   expect_of = r;
         default: expect_of = p;
      endcase
   endfunction

   task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Check both banks and their complements against the model.
   task automatic check_all();
      logic [W-1:0] de, be;
      de = expect_of(ded_mode, ded_pin, d_lat, d_reg);
      be = expect_of(bio_mode, bio_pin, b_lat, b_reg);
      chk(tag_of(ded_mode, cap_ctl), ded_true, de);
      chk(tag_of(bio_mode, cap_ctl), bio_true, be);
      chk("R7", ded_comp, ~de);
      chk("R7", bio_comp, ~be);
   endtask

   task automatic set_pins(logic [W-1:0] d, logic [W-1:0] b);
      ded_pin = d;
      bio_pin = b;
      if (cap_ctl) begin
         d_lat = d;
         b_lat = b;
      end
      #1;
   endtask

   task automatic ctl_rise();
      cap_ctl = 1'b1;
      d_reg = cfg_rst ? '0 : ded_pin;
      b_reg = cfg_rst ? '0 : bio_pin;
      d_lat = ded_pin;
      b_lat = bio_pin;
      #1;
   endtask

   task automatic ctl_fall();
      cap_ctl = 1'b0;
      #1;
   endtask

   initial begin
      #(PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cap_ctl  = 1'b0;
      cfg_rst  = 1'b1;
      ded_mode = 2'b10;
      bio_mode = 2'b10;
      ded_pin  = '1;
      bio_pin  = '1;
      d_lat = '0; b_lat = '0; d_reg = '0; b_reg = '0;
      #1;
      ctl_rise();
      // R6: reset state of the capture registers.
      chk("R6", ded_true, '0);
      chk("R6", bio_true, '0);
      chk("R7", ded_comp, '1);
      ctl_fall();
      cfg_rst = 1'b0;
      #1;

      // Sweep of every mode pair and every pin value.
      for (int dm = 0; dm < 4; dm++) begin
         for (int bm = 0; bm < 4; bm++) begin
            ded_mode = dm[1:0];
            bio_mode = bm[1:0];
            for (int v = 0; v < 16; v++) begin
               set_pins(v[W-1:0], v[W-1:0] ^ 4'hA);
               check_all();
               ctl_rise();
               check_all();
               set_pins(v[W-1:0] + 4'd5, v[W-1:0] ^ 4'h3);
               check_all();
               ctl_fall();
               check_all();
               set_pins(v[W-1:0] + 4'd9, ~v[W-1:0]);
               check_all();
            end
         end
      end

      // R8: registered dedicated bank beside a pass-through bidirectional bank.
      ded_mode = 2'b10;
      bio_mode = 2'b00;
      set_pins(4'h6, 4'h6);
      ctl_rise();
      ctl_fall();
      set_pins(4'h9, 4'h9);
      chk("R8", ded_true, 4'h6);
      chk("R8", bio_true, 4'h9);

      // R8: swap the modes; the dedicated bank now passes, bidirectional holds.
      ded_mode = 2'b00;
      bio_mode = 2'b10;
      #1;
      chk("R8", ded_true, 4'h9);
      chk("R8", bio_true, 4'h6);

      // R6: mid-run clear while registered.
      ded_mode = 2'b10;
      set_pins(4'hF, 4'hF);
      ctl_rise();
      chk("R5", ded_true, 4'hF);
      ctl_fall();
      cfg_rst = 1'b1;
      #1;
      ctl_rise();
      chk("R6", ded_true, 4'h0);
      chk("R6", bio_true, 4'h0);
      ctl_fall();
      cfg_rst = 1'b0;
      #1;

      // R4: latched hold, while the pins change with the control pin low.
      ded_mode = 2'b01;
      set_pins(4'hC, 4'h3);
      ctl_rise();
      ctl_fall();
      set_pins(4'h1, 4'h2);
      chk("R4", ded_true, 4'hC);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule